// File: doc/BRIEF.md
# Processor Address Decoder with Boot Remap

This block sits between a processor's memory request port and the targets behind it. Each request carries a 32-bit address. The block sorts that address into one of eight target regions: boot ROM/flash, card socket 0, card socket 1, extension port, DSP shared memory, on-chip register space, system memory and a zero bank. It raises one select line for the chosen region. Beside the select it presents a 27-bit physical address and, for the register space, the index of the 64 KB peripheral slot.

A small boot-status register is held inside the block. It has a cold-boot bit and a warm-boot bit, and software reads and writes it at one word of the register space. While the cold-boot bit is set, the lowest 256 MB window points at system memory instead of the ROM. The upper ROM half (the mirror) keeps reaching the ROM, so boot code stays reachable.

Requests to unmapped space never reach a target. A read there gets an abort response. A write there completes quietly and changes nothing. Reads of the zero bank are answered inside the block with all-zero data. Writes to the zero bank are acknowledged and have no effect.

The controller is a six-state machine:
- IDLE accepts a request and moves, by its decoded class, to ACCESS, ZERO, BOOTREG, ABORT or DROP.
- ACCESS holds the region select until the target signals done.
- ZERO, BOOTREG, ABORT and DROP each answer in one cycle.
- Every state other than IDLE returns to IDLE in the cycle its response is given.

Top module: `bootmap_decoder`

## Requirements
- R1: With the cold-boot bit clear, a request to a mapped address raises exactly one bit of tgt_sel during the target access. The region ranges and their tgt_sel bits are:
  - bit0 ROM: 0x0000_0000–0x1FFF_FFFF
  - bit1 socket 0: 0x2000_0000–0x2FFF_FFFF
  - bit2 socket 1: 0x3000_0000–0x3FFF_FFFF
  - bit3 extension port: 0x4000_0000–0x47FF_FFFF
  - bit4 DSP memory: 0x4800_0000–0x4FFF_FFFF
  - bit5 register space: 0x8000_0000–0xBFFF_FFFF
  - bit6 system memory: 0xC000_0000–0xDFFF_FFFF
  - bit7 zero bank: 0xE000_0000–0xE7FF_FFFF
- R2: Before remap, addresses 0x0000_0000+x and 0x1000_0000+x both select the ROM (bit0) with the same physical address.
- R3: While the cold-boot bit is set, 0x0000_0000–0x0FFF_FFFF selects system memory (bit6), and 0x1000_0000–0x1FFF_FFFF still selects the ROM (bit0).
- R4: A read of 0x5000_0000–0x7FFF_FFFF or of 0xE800_0000 and above raises no select and gives one response with rsp_abort=1 and rsp_rdata=0.
- R5: A write to those reserved ranges raises no select, gives one response with rsp_abort=0, and changes no state that a later access can see.
- R6: tgt_addr equals request address bits 26:0 during a target access. tgt_write and tgt_wdata follow the request.
- R7: For the register space, tgt_slot equals address bits 29:16. For every other region it is 0.
- R8: The boot-status register sits at slot BOOT_SLOT (default 3), word 0, which is address 0x8003_0000. A write sets the cold bit from wdata bit0 and the warm bit from wdata bit1. A read returns {30'b0, warm, cold}. Neither access raises a select. Both bits are 0 after reset.
- R9: A zero-bank request raises tgt_sel bit7 for one cycle with rsp_valid=1, rsp_rdata=0 and rsp_abort=0, whatever tgt_rdata carries.
- R10: A change to the cold-boot bit applies to the first request accepted after the boot-register write responds.
- R11: req_ready is 1 only in IDLE. During ACCESS the select stays high until tgt_done. The response comes in the tgt_done cycle, carries tgt_rdata, and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Processor address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response strobe |
| rsp_abort | output | 1 | Response is an abort |
| rsp_rdata | output | DATA_W | Read data |
| tgt_sel | output | 8 | One select per region |
| tgt_write | output | 1 | Access direction to target |
| tgt_addr | output | 27 | Physical address |
| tgt_slot | output | 14 | Peripheral slot in register space |
| tgt_wdata | output | DATA_W | Write data to target |
| tgt_rdata | input | DATA_W | Target read data |
| tgt_done | input | 1 | Target completes the access |

## Verification
The assertions assume that tgt_done is raised only while a select from bit0 to bit6 is high. They also assume that a request is held only while req_ready can accept it. The bench meets both conditions. It raises a single request for one accepted cycle, drops req_valid before the machine returns to IDLE, and drives tgt_done only after it has seen a target select. It also keeps a non-zero value on tgt_rdata between accesses, so that zero-bank and abort data cannot come from the target.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
    localparam int ADDR_W   = 32;
    localparam int PHYS_W   = 27;
    localparam int SLOT_LSB = 16;
    localparam int SLOT_W   = 30 - SLOT_LSB;
    localparam int NUM_SEL  = 8;

    typedef enum logic [3:0] {
        RG_ROM  = 4'd0,
        RG_SCK0 = 4'd1,
        RG_SCK1 = 4'd2,
        RG_EXTP = 4'd3,
        RG_DSPM = 4'd4,
        RG_REGS = 4'd5,
        RG_SYSM = 4'd6,
        RG_ZERO = 4'd7,
        RG_RESV = 4'd8
    } region_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_ZERO,
        ST_BOOTREG,
        ST_ABORT,
        ST_DROP
    } state_t;
endpackage

// File: rtl/bootmap_region_dec.sv
module bootmap_region_dec
    import bootmap_pkg::*;
#(
    parameter logic [SLOT_W-1:0] BOOT_SLOT = 14'd3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cold,
    output region_t           region,
    output logic [PHYS_W-1:0] phys,
    output logic [SLOT_W-1:0] slot,
    output logic              boot_hit
);
    localparam int SLOT_MSB = SLOT_LSB + SLOT_W - 1;

    always_comb begin
        region = RG_RESV;
        unique case (addr[31:28])
            4'h0:                region = cold ? RG_SYSM : RG_ROM;
            4'h1:                region = RG_ROM;
            4'h2:                region = RG_SCK0;
            4'h3:                region = RG_SCK1;
            4'h4:                region = addr[27] ? RG_DSPM : RG_EXTP;
            4'h5, 4'h6, 4'h7:    region = RG_RESV;
            4'h8, 4'h9, 4'hA,
            4'hB:                region = RG_REGS;
            4'hC, 4'hD:          region = RG_SYSM;
            4'hE:                region = addr[27] ? RG_RESV : RG_ZERO;
            4'hF:                region = RG_RESV;
            default:             region = RG_RESV;
        endcase
    end

    assign phys     = addr[PHYS_W-1:0];
    assign slot     = (region == RG_REGS) ? addr[SLOT_MSB:SLOT_LSB] : '0;
    assign boot_hit = (region == RG_REGS) && (addr[SLOT_MSB:SLOT_LSB] == BOOT_SLOT)
                      && (addr[SLOT_LSB-1:2] == '0);
endmodule

// File: rtl/bootmap_bootreg.sv
module bootmap_bootreg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic cold_in,
    input  logic warm_in,
    output logic cold,
    output logic warm
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cold <= 1'b0;
            warm <= 1'b0;
        end else if (wr_en) begin
            cold <= cold_in;
            warm <= warm_in;
        end
    end

    AST_BOOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cold) && $stable(warm))) else $error("boot bits moved"); // R8
endmodule

// File: rtl/bootmap_fsm.sv
module bootmap_fsm
    import bootmap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  region_t           dec_region,
    input  logic [PHYS_W-1:0] dec_phys,
    input  logic [SLOT_W-1:0] dec_slot,
    input  logic              dec_boot_hit,
    input  logic              boot_cold,
    input  logic              boot_warm,
    input  logic [DATA_W-1:0] tgt_rdata,
    input  logic              tgt_done,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_abort,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [NUM_SEL-1:0] tgt_sel,
    output logic              tgt_write,
    output logic [PHYS_W-1:0] tgt_addr,
    output logic [SLOT_W-1:0] tgt_slot,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              boot_wr
);
    state_t            state, state_nx;
    region_t           lat_region;
    logic [PHYS_W-1:0] lat_phys;
    logic [SLOT_W-1:0] lat_slot;
    logic              lat_write;
    logic [DATA_W-1:0] lat_wdata;
    logic              accept;

    assign accept = req_valid && (state == ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_region == RG_RESV)
                        state_nx = req_write ? ST_DROP : ST_ABORT;
                    else if (dec_region == RG_ZERO)
                        state_nx = ST_ZERO;
                    else if (dec_boot_hit)
                        state_nx = ST_BOOTREG;
                    else
                        state_nx = ST_ACCESS;
                end
            end
            ST_ACCESS:  if (tgt_done) state_nx = ST_IDLE;
            ST_ZERO:    state_nx = ST_IDLE;
            ST_BOOTREG: state_nx = ST_IDLE;
            ST_ABORT:   state_nx = ST_IDLE;
            ST_DROP:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lat_region <= RG_RESV;
            lat_phys   <= '0;
            lat_slot   <= '0;
            lat_write  <= 1'b0;
            lat_wdata  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                lat_region <= dec_region;
                lat_phys   <= dec_phys;
                lat_slot   <= dec_slot;
                lat_write  <= req_write;
                lat_wdata  <= req_wdata;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_abort = 1'b0;
        rsp_rdata = '0;
        tgt_sel   = '0;
        boot_wr   = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_ACCESS: begin
                tgt_sel[lat_region[2:0]] = 1'b1;
                rsp_valid = tgt_done;
                rsp_rdata = tgt_done ? tgt_rdata : '0;
            end
            ST_ZERO: begin
                tgt_sel[RG_ZERO] = 1'b1;
                rsp_valid = 1'b1;
            end
            ST_BOOTREG: begin
                rsp_valid = 1'b1;
                boot_wr   = lat_write;
                if (!lat_write)
                    rsp_rdata = {{(DATA_W-2){1'b0}}, boot_warm, boot_cold};
            end
            ST_ABORT: begin
                rsp_valid = 1'b1;
                rsp_abort = 1'b1;
            end
            ST_DROP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign tgt_write = lat_write;
    assign tgt_addr  = lat_phys;
    assign tgt_slot  = lat_slot;
    assign tgt_wdata = lat_wdata;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel)) else $error("multiple selects"); // R1
    AST_ABORT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> (!tgt_write && tgt_sel == '0)) else $error("abort on write"); // R4
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |-> (tgt_sel == '0 && !rsp_abort && !boot_wr)) else $error("drop leaked"); // R5
    AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[RG_ZERO] |-> (rsp_valid && rsp_rdata == '0 && !rsp_abort)) else $error("zero bank data"); // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)) else $error("response too long"); // R11
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel[6:0] != '0 && !tgt_done) |=> $stable(tgt_sel)) else $error("select dropped"); // R11
endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
    import bootmap_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [SLOT_W-1:0] BOOT_SLOT = 14'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic               rsp_abort,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [NUM_SEL-1:0] tgt_sel,
    output logic               tgt_write,
    output logic [PHYS_W-1:0]  tgt_addr,
    output logic [SLOT_W-1:0]  tgt_slot,
    output logic [DATA_W-1:0]  tgt_wdata,
    input  logic [DATA_W-1:0]  tgt_rdata,
    input  logic               tgt_done
);
    region_t           dec_region;
    logic [PHYS_W-1:0] dec_phys;
    logic [SLOT_W-1:0] dec_slot;
    logic              dec_boot_hit;
    logic              boot_cold, boot_warm, boot_wr;

    bootmap_region_dec #(.BOOT_SLOT(BOOT_SLOT)) u_dec (
        .addr     (req_addr),
        .cold     (boot_cold),
        .region   (dec_region),
        .phys     (dec_phys),
        .slot     (dec_slot),
        .boot_hit (dec_boot_hit)
    );

    bootmap_bootreg u_boot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (boot_wr),
        .cold_in (tgt_wdata[0]),
        .warm_in (tgt_wdata[1]),
        .cold    (boot_cold),
        .warm    (boot_warm)
    );

    bootmap_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .dec_region   (dec_region),
        .dec_phys     (dec_phys),
        .dec_slot     (dec_slot),
        .dec_boot_hit (dec_boot_hit),
        .boot_cold    (boot_cold),
        .boot_warm    (boot_warm),
        .tgt_rdata    (tgt_rdata),
        .tgt_done     (tgt_done),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_abort    (rsp_abort),
        .rsp_rdata    (rsp_rdata),
        .tgt_sel      (tgt_sel),
        .tgt_write    (tgt_write),
        .tgt_addr     (tgt_addr),
        .tgt_slot     (tgt_slot),
        .tgt_wdata    (tgt_wdata),
        .boot_wr      (boot_wr)
    );
endmodule

// File: tb/bootmap_decoder_test.sv
module bootmap_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_abort;
    logic [31:0] rsp_rdata, tgt_wdata;
    logic [7:0]  tgt_sel;
    logic        tgt_write;
    logic [26:0] tgt_addr;
    logic [13:0] tgt_slot;
    logic [31:0] tgt_rdata = 32'hDEAD_BEEF;
    logic        tgt_done = 1'b0;

    int total = 0, bad = 0;

    logic [7:0]  o_sel;
    logic [26:0] o_phys;
    logic [13:0] o_slot;
    logic        o_wr, o_rsp, o_abort;
    logic [31:0] o_rdata, o_wdata;
    int          o_selcyc;

    bootmap_decoder uut (.*);

    always #4 clk = ~clk;

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [31:0] model(input logic [26:0] p);
        return {5'h15, p};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd, input int lat);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        o_sel = '0; o_rsp = 1'b0; o_abort = 1'b0; o_rdata = '0; o_selcyc = 0;
        o_phys = '0; o_slot = '0; o_wr = 1'b0; o_wdata = '0;
        n = 0;
        while (!o_rsp && n < 20) begin
            #1;
            if (tgt_sel != '0) begin
                o_sel = tgt_sel; o_phys = tgt_addr; o_slot = tgt_slot;
                o_wr = tgt_write; o_wdata = tgt_wdata; o_selcyc++;
            end
            if (tgt_sel[6:0] != '0 && n >= lat) begin
                tgt_done = 1'b1; tgt_rdata = model(tgt_addr);
                #1;
            end
            if (rsp_valid) begin
                o_rsp = 1'b1; o_abort = rsp_abort; o_rdata = rsp_rdata;
            end
            @(negedge clk);
            tgt_done = 1'b0; tgt_rdata = 32'hDEAD_BEEF;
            n++;
        end
    endtask

    task automatic expect_target(input logic [31:0] a, input logic [7:0] sel_exp, input string req);
        logic [13:0] slot_exp;
        access(1'b0, a, '0, 1);
        slot_exp = (a[31:30] == 2'b10) ? a[29:16] : 14'd0;
        check(o_sel == sel_exp, req, {24'h0, o_sel}, {24'h0, sel_exp});
        check(o_phys == a[26:0], "R6 phys", {5'h0, o_phys}, {5'h0, a[26:0]});
        check(o_slot == slot_exp, "R7 slot", {18'h0, o_slot}, {18'h0, slot_exp});
        check(o_rsp && !o_abort && o_rdata == model(a[26:0]), "R11 rdata", o_rdata, model(a[26:0]));
    endtask

    task automatic t_reset;
        #1;
        check(tgt_sel == '0, "R11 reset sel", {24'h0, tgt_sel}, 32'h0);
        check(req_ready && !rsp_valid, "R11 reset ready", {30'h0, req_ready, rsp_valid}, 32'h2);
        access(1'b0, 32'h8003_0000, '0, 0);
        check(o_rsp && o_rdata == 32'h0 && o_sel == '0, "R8 reset value", o_rdata, 32'h0);
    endtask

    task automatic t_regions;
        expect_target(32'h0123_4560, 8'h01, "R1 rom");
        expect_target(32'h2ABC_0004, 8'h02, "R1 socket0");
        expect_target(32'h3FFF_FFFC, 8'h04, "R1 socket1");
        expect_target(32'h4000_0010, 8'h08, "R1 ext");
        expect_target(32'h47FF_FFFC, 8'h08, "R1 ext top");
        expect_target(32'h4800_0000, 8'h10, "R1 dsp");
        expect_target(32'h4FFF_FFFC, 8'h10, "R1 dsp top");
        expect_target(32'h8005_1234, 8'h20, "R1 regs");
        expect_target(32'hBFFF_0008, 8'h20, "R1 regs top");
        expect_target(32'hC000_0100, 8'h40, "R1 sysmem");
        expect_target(32'hDFFF_FFFC, 8'h40, "R1 sysmem top");
    endtask

    task automatic t_mirror;
        logic [26:0] p0;
        logic [31:0] d0;
        access(1'b0, 32'h0000_0040, '0, 0);
        p0 = o_phys; d0 = o_rdata;
        check(o_sel == 8'h01, "R2 low rom", {24'h0, o_sel}, 32'h1);
        access(1'b0, 32'h1000_0040, '0, 0);
        check(o_sel == 8'h01, "R2 mirror rom", {24'h0, o_sel}, 32'h1);
        check(o_phys == p0 && o_rdata == d0, "R2 same data", o_rdata, d0);
    endtask

    task automatic t_reserved;
        logic [31:0] ra [4] = '{32'h5000_0000, 32'h7FFF_FFFC, 32'hE800_0000, 32'hFFFF_FFFC};
        for (int i = 0; i < 4; i++) begin
            access(1'b0, ra[i], '0, 0);
            check(o_rsp && o_abort && o_sel == '0 && o_rdata == '0, "R4 abort", {o_abort, 23'h0, o_sel}, 32'h8000_0000);
            access(1'b1, ra[i], 32'h0000_0003, 0);
            check(o_rsp && !o_abort && o_sel == '0, "R5 drop", {o_abort, 23'h0, o_sel}, 32'h0);
        end
        access(1'b0, 32'h8003_0000, '0, 0);
        check(o_rdata == 32'h0, "R5 no side effect", o_rdata, 32'h0);
    endtask

    task automatic t_zero;
        access(1'b0, 32'hE000_0000, '0, 0);
        check(o_rsp && !o_abort && o_rdata == 0 && o_sel == 8'h80 && o_selcyc == 1, "R9 zero base", o_rdata, 32'h0);
        access(1'b0, 32'hE7FF_FFFC, '0, 0);
        check(o_rsp && !o_abort && o_rdata == 0 && o_sel == 8'h80, "R9 zero top", {24'h0, o_sel}, 32'h80);
    endtask

    task automatic t_write_path;
        access(1'b1, 32'h2000_0100, 32'hCAFE_0001, 2);
        check(o_sel == 8'h02 && o_wr && o_wdata == 32'hCAFE_0001, "R6 write path", o_wdata, 32'hCAFE_0001);
    endtask

    task automatic t_latency;
        access(1'b0, 32'h4800_0200, '0, 3);
        check(o_selcyc == 4, "R11 select held", o_selcyc, 4);
        check(o_rsp && o_rdata == model(27'h000_0200), "R11 response data", o_rdata, model(27'h000_0200));
        @(negedge clk); #1;
        check(req_ready && !rsp_valid, "R11 back to idle", {30'h0, req_ready, rsp_valid}, 32'h2);
    endtask

    task automatic t_bootreg;
        access(1'b1, 32'h8003_0000, 32'h0000_0002, 0);
        check(o_rsp && o_sel == '0 && !o_abort, "R8 write no select", {24'h0, o_sel}, 32'h0);
        access(1'b0, 32'h8003_0000, '0, 0);
        check(o_rdata == 32'h2, "R8 warm bit", o_rdata, 32'h2);
        access(1'b0, 32'h0000_0800, '0, 0);
        check(o_sel == 8'h01, "R8 warm leaves rom", {24'h0, o_sel}, 32'h1);
    endtask

    task automatic t_remap;
        access(1'b1, 32'h8003_0000, 32'h0000_0001, 0);
        access(1'b0, 32'h0000_1000, '0, 0);
        check(o_sel == 8'h40 && o_phys == 27'h1000, "R10 first access remapped", {24'h0, o_sel}, 32'h40);
        access(1'b0, 32'h0FFF_FFFC, '0, 0);
        check(o_sel == 8'h40 && o_phys == 27'h7FF_FFFC, "R3 low window top", {24'h0, o_sel}, 32'h40);
        access(1'b0, 32'h1000_1000, '0, 0);
        check(o_sel == 8'h01, "R3 mirror rom", {24'h0, o_sel}, 32'h1);
        access(1'b0, 32'h8003_0000, '0, 0);
        check(o_rdata == 32'h1, "R8 cold bit", o_rdata, 32'h1);
        access(1'b1, 32'h8003_0000, 32'h0000_0000, 0);
        access(1'b0, 32'h0000_1000, '0, 0);
        check(o_sel == 8'h01, "R10 remap cleared", {24'h0, o_sel}, 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_regions();
        t_mirror();
        t_reserved();
        t_zero();
        t_write_path();
        t_latency();
        t_bootreg();
        t_remap();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule